// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the instruction fetch address for a core whose instructions are all 16 bits wide and whose branches are delayed by one slot. It holds the program counter as a short pipeline of three stages (current, next and the one after) with a matching pipeline for the procedure-return value. Each clock cycle is one instruction step. The block presents the fetch address for the instruction now executing, and the decoder returns, in the same cycle, what that instruction turned out to be: a defined or undefined opcode, a taken delayed branch with its target, and whether the branch is also a procedure call.

A taken branch overwrites only the furthest stage, so the instruction that already sits behind the branch still runs as the delay slot before control reaches the target. Undefined opcodes trap to one of two vectors, and which one depends on whether the instruction sits in a delay slot. An external synchronous event request is never accepted between a branch and its slot. It is parked and taken on the step after the slot. All outputs are registered. An exception is reported in the cycle that follows the faulting step, together with the first fetch from the handler vector.

Top module: `dbr_pc_seq`

## Requirements
- R1: After reset, with no branch, exception or event, `fetch_addr` increases by 2 on every clock.
- R2: `fetch_addr` bit 0 is always 0. Bit 0 of a branch target is discarded.
- R3: When a delayed branch is taken, the next fetch is the instruction that sequentially follows the branch (the delay slot). The fetch after that is the branch target.
- R4: `in_slot` is 1 for exactly the one step that follows a taken branch, and 0 at every other step.
- R5: A taken branch with `dec_call` set loads the return value with the address of the slot plus 2. This value appears on `pr_cur` from the target instruction onward and stays there through later steps and exceptions.
- R6: An undefined opcode outside a delay slot gives, on the next cycle, `exc_valid`=1, `exc_code`=1 (reserved instruction) and `fetch_addr`=`VEC_RSV`. Fetching then continues at `VEC_RSV`+2.
- R7: An undefined opcode in a delay slot gives `exc_valid`=1, `exc_code`=2 (slot illegal) and `fetch_addr`=`VEC_SLOT`. A branch decoded in a delay slot counts as undefined in the same way.
- R8: `evt_req` during a non-slot step gives `exc_valid`=1, `exc_code`=3 and `fetch_addr`=`VEC_EVT` on the next cycle. During a delay-slot step it is held, the slot completes normally, and the event is taken on the following step.
- R9: When an undefined opcode and an event occur in the same step, the undefined-opcode exception is taken and the event stays pending until the next step.
- R10: Synchronous reset gives `fetch_addr`=`RESET_ADDR`, `in_slot`=0, `exc_valid`=0, `exc_code`=0 and `pr_cur`=0, and it discards a pending event.
- R11: An exception clears the delay-slot state. `exc_valid` is 0 and `exc_code` is 0 on any cycle that follows a step without an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_undef | input | 1 | Instruction at `fetch_addr` is undefined |
| dec_branch | input | 1 | Instruction is a taken delayed branch |
| dec_call | input | 1 | The branch is a procedure call |
| dec_target | input | ADDR_W | Branch target address |
| evt_req | input | 1 | Synchronous event request |
| fetch_addr | output | ADDR_W | Address of the current instruction |
| in_slot | output | 1 | Current instruction is a delay slot |
| pr_cur | output | ADDR_W | Current procedure-return value |
| exc_valid | output | 1 | Previous step raised an exception |
| exc_code | output | 2 | 0 none, 1 reserved instruction, 2 slot illegal, 3 event |

## Verification
The hardest situations to reach are those that occur only inside a delay slot: an undefined opcode there, a second branch there, and an event request that has to be deferred across the slot. None of these can be forced directly. The stimulus therefore first drives a taken branch and then, on the very next step, places the fault or the event request. A further vector combines an event with an undefined opcode, so that the pending event can be seen being taken one step late. A reset issued while an event is parked inside a slot checks that the pending event is discarded.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_RSV  = 2'd1,
    EXC_SLOT = 2'd2,
    EXC_EVT  = 2'd3
  } exc_t;

  localparam int INSN_BYTES = 2;
endpackage

// File: rtl/dbr_exc_arb.sv
module dbr_exc_arb
  import dbr_pkg::*;
(
  input  logic in_slot,
  input  logic dec_undef,
  input  logic dec_branch,
  input  logic evt_req,
  input  logic evt_pend,
  output logic take,
  output exc_t code,
  output logic br_take,
  output logic pend_next
);
  logic bad_op;
  logic evt_any;

  always_comb begin
    // a branch sitting in a slot is treated like an undefined opcode
    bad_op  = dec_undef | (dec_branch & in_slot);
    evt_any = evt_req | evt_pend;
    code    = EXC_NONE;
    if (bad_op)
      code = in_slot ? EXC_SLOT : EXC_RSV;
    else if (evt_any && !in_slot)
      code = EXC_EVT;
    take      = (code != EXC_NONE);
    br_take   = dec_branch & ~take;
    pend_next = evt_any & (code != EXC_EVT);
  end
endmodule

// File: rtl/dbr_pc_stages.sv
module dbr_pc_stages #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap,
  input  logic [ADDR_W-1:0] trap_vec,
  input  logic              br_take,
  input  logic              call_take,
  input  logic [ADDR_W-1:0] br_tgt,
  output logic [ADDR_W-1:0] pc_cur,
  output logic [ADDR_W-1:0] pr_cur
);
  localparam int NSTG = 3;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(dbr_pkg::INSN_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q [NSTG];
  logic [ADDR_W-1:0] pr_q [NSTG];
  logic [ADDR_W-1:0] pc_d [NSTG];
  logic [ADDR_W-1:0] pr_d [NSTG];
  logic [ADDR_W-1:0] pc_rst [NSTG];

  assign pc_rst[0] = RESET_ADDR & ALIGN_MASK;
  assign pc_rst[1] = RESET_ADDR & ALIGN_MASK;
  assign pc_rst[2] = (RESET_ADDR & ALIGN_MASK) + STEP;

  always_comb begin
    // step order: next <- next-next, next-next <- next + 2, current <- next
    pc_d[1] = pc_q[2];
    pc_d[2] = pc_q[2] + STEP;
    pr_d[1] = pr_q[2];
    pr_d[2] = pr_q[2];
    if (br_take)
      pc_d[2] = br_tgt & ALIGN_MASK;
    if (br_take && call_take)
      pr_d[2] = pc_q[2] + STEP;
    pc_d[0] = pc_d[1];
    pr_d[0] = pr_d[1];
    if (trap) begin
      pc_d[0] = trap_vec & ALIGN_MASK;
      pc_d[1] = trap_vec & ALIGN_MASK;
      pc_d[2] = (trap_vec & ALIGN_MASK) + STEP;
      pr_d[0] = pr_q[0];
      pr_d[1] = pr_q[1];
      pr_d[2] = pr_q[2];
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q[g] <= pc_rst[g];
        pr_q[g] <= '0;
      end else begin
        pc_q[g] <= pc_d[g];
        pr_q[g] <= pr_d[g];
      end
    end
  end

  assign pc_cur = pc_q[0];
  assign pr_cur = pr_q[0];
endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] VEC_RSV    = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] VEC_SLOT   = 32'h0000_0200,
  parameter logic [ADDR_W-1:0] VEC_EVT    = 32'h0000_0300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_undef,
  input  logic              dec_branch,
  input  logic              dec_call,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic              evt_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              in_slot,
  output logic [ADDR_W-1:0] pr_cur,
  output logic              exc_valid,
  output logic [1:0]        exc_code
);
  logic              slot_q, pend_q, exv_q;
  exc_t              code_q;
  logic              take, br_take, pend_next;
  exc_t              code;
  logic [ADDR_W-1:0] vec;

  dbr_exc_arb u_arb (
    .in_slot   (slot_q),
    .dec_undef (dec_undef),
    .dec_branch(dec_branch),
    .evt_req   (evt_req),
    .evt_pend  (pend_q),
    .take      (take),
    .code      (code),
    .br_take   (br_take),
    .pend_next (pend_next)
  );

  always_comb begin
    unique case (code)
      EXC_SLOT: vec = VEC_SLOT;
      EXC_EVT:  vec = VEC_EVT;
      default:  vec = VEC_RSV;
    endcase
  end

  dbr_pc_stages #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_stg (
    .clk      (clk),
    .rst      (rst),
    .trap     (take),
    .trap_vec (vec),
    .br_take  (br_take),
    .call_take(dec_call),
    .br_tgt   (dec_target),
    .pc_cur   (fetch_addr),
    .pr_cur   (pr_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= 1'b0;
      pend_q <= 1'b0;
      exv_q  <= 1'b0;
      code_q <= EXC_NONE;
    end else begin
      slot_q <= br_take;
      pend_q <= pend_next;
      exv_q  <= take;
      code_q <= code;
    end
  end

  assign in_slot   = slot_q;
  assign exc_valid = exv_q;
  assign exc_code  = code_q;
endmodule

// File: rtl/dbr_pc_seq_chk.sv
module dbr_pc_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_undef,
  input logic              dec_branch,
  input logic              evt_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              in_slot,
  input logic              exc_valid,
  input logic [1:0]        exc_code
);
  assert_align_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[0] == 1'b0);

  assert_slot_once_R4: assert property (@(posedge clk) disable iff (rst)
    in_slot |=> !in_slot);

  assert_slot_cause_R4: assert property (@(posedge clk) disable iff (rst)
    in_slot |-> ($past(dec_branch) && !$past(in_slot)));

  assert_rsv_outside_R6: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_code == 2'd1) |-> !$past(in_slot));

  assert_slot_inside_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_code == 2'd2) |-> $past(in_slot));

  assert_evt_holdoff_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_code == 2'd3) |-> !$past(in_slot));

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !in_slot);

  assert_code_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> exc_code == 2'd0);
endmodule

bind dbr_pc_seq dbr_pc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_undef (dec_undef),
  .dec_branch(dec_branch),
  .evt_req   (evt_req),
  .fetch_addr(fetch_addr),
  .in_slot   (in_slot),
  .exc_valid (exc_valid),
  .exc_code  (exc_code)
);

// File: tb/sim_dbr_pc_seq.sv
module sim_dbr_pc_seq;
  localparam int AW = 32;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_undef = 1'b0, dec_branch = 1'b0, dec_call = 1'b0, evt_req = 1'b0;
  logic [AW-1:0] dec_target = '0;
  logic [AW-1:0] fetch_addr, pr_cur;
  logic in_slot, exc_valid;
  logic [1:0] exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbr_pc_seq u0 (
    .clk(clk), .rst(rst), .dec_undef(dec_undef), .dec_branch(dec_branch),
    .dec_call(dec_call), .dec_target(dec_target), .evt_req(evt_req),
    .fetch_addr(fetch_addr), .in_slot(in_slot), .pr_cur(pr_cur),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );

  // stimulus: {undef, branch, call, evt, target}
  localparam logic [35:0] STIM [NV] = '{
    {4'b0000, 32'h0},        // 0  R1
    {4'b0000, 32'h0},        // 1  R1
    {4'b0100, 32'h2000},     // 2  R3 branch
    {4'b0000, 32'h0},        // 3  R3 slot
    {4'b0000, 32'h0},        // 4  R1
    {4'b0110, 32'h3001},     // 5  R2 R5 call, odd target
    {4'b0000, 32'h0},        // 6  R5 slot
    {4'b1000, 32'h0},        // 7  R6
    {4'b0000, 32'h0},        // 8  R6
    {4'b0100, 32'h0400},     // 9  R4
    {4'b1000, 32'h0},        // 10 R7 undef in slot
    {4'b0100, 32'h0500},     // 11 R4
    {4'b0100, 32'h0600},     // 12 R7 branch in slot
    {4'b0100, 32'h0700},     // 13 R4
    {4'b0001, 32'h0},        // 14 R8 event in slot held
    {4'b0000, 32'h0},        // 15 R8 taken
    {4'b0001, 32'h0},        // 16 R8 outside slot
    {4'b1001, 32'h0},        // 17 R9
    {4'b0000, 32'h0},        // 18 R9 pending event
    {4'b0000, 32'h0}         // 19 R11
  };
  // expected: {fetch, slot, exc_valid, code, pr}
  localparam logic [67:0] EXP [NV] = '{
    {32'h1002, 1'b0, 1'b0, 2'd0, 32'h0},
    {32'h1004, 1'b0, 1'b0, 2'd0, 32'h0},
    {32'h1006, 1'b1, 1'b0, 2'd0, 32'h0},
    {32'h2000, 1'b0, 1'b0, 2'd0, 32'h0},
    {32'h2002, 1'b0, 1'b0, 2'd0, 32'h0},
    {32'h2004, 1'b1, 1'b0, 2'd0, 32'h0},
    {32'h3000, 1'b0, 1'b0, 2'd0, 32'h2006},
    {32'h0100, 1'b0, 1'b1, 2'd1, 32'h2006},
    {32'h0102, 1'b0, 1'b0, 2'd0, 32'h2006},
    {32'h0104, 1'b1, 1'b0, 2'd0, 32'h2006},
    {32'h0200, 1'b0, 1'b1, 2'd2, 32'h2006},
    {32'h0202, 1'b1, 1'b0, 2'd0, 32'h2006},
    {32'h0200, 1'b0, 1'b1, 2'd2, 32'h2006},
    {32'h0202, 1'b1, 1'b0, 2'd0, 32'h2006},
    {32'h0700, 1'b0, 1'b0, 2'd0, 32'h2006},
    {32'h0300, 1'b0, 1'b1, 2'd3, 32'h2006},
    {32'h0300, 1'b0, 1'b1, 2'd3, 32'h2006},
    {32'h0100, 1'b0, 1'b1, 2'd1, 32'h2006},
    {32'h0300, 1'b0, 1'b1, 2'd3, 32'h2006},
    {32'h0302, 1'b0, 1'b0, 2'd0, 32'h2006}
  };

  task automatic drive(input logic [35:0] s);
    {dec_undef, dec_branch, dec_call, evt_req, dec_target} = s;
  endtask

  task automatic check(input string req, input logic [67:0] exp);
    logic [67:0] act;
    act = {fetch_addr, in_slot, exc_valid, exc_code, pr_cur};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual fetch=%h slot=%b exc=%b code=%0d pr=%h expected fetch=%h slot=%b exc=%b code=%0d pr=%h",
               req, act[67:36], act[35], act[34], act[33:32], act[31:0],
               exp[67:36], exp[35], exp[34], exp[33:32], exp[31:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {32'h1000, 1'b0, 1'b0, 2'd0, 32'h0});
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(STIM[i]);
      @(negedge clk);
      check($sformatf("vector %0d (R1..R11 table)", i), EXP[i]);
    end
    drive('0);
    // R10: reset while an event is parked in a slot discards it
    drive({4'b0100, 32'h0800});
    @(negedge clk);
    check("R4 slot before reset", {32'h0304, 1'b1, 1'b0, 2'd0, 32'h2006});
    drive({4'b0001, 32'h0});
    rst = 1'b1;
    @(negedge clk);
    drive('0);
    check("R10 mid-run reset", {32'h1000, 1'b0, 1'b0, 2'd0, 32'h0});
    rst = 1'b0;
    // R1: straight-line run, pending event must be gone (R10)
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R1 straight line", {32'h1000 + 32'(2 * k), 1'b0, 1'b0, 2'd0, 32'h0});
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule